// File: doc/BRIEF.md
# Double-Buffered Framebuffer Bank Switch

This block sits between two identical video memory banks, a display scanner and a drawing engine. At any moment one bank is live: the scanner's X/Y address is routed to it and its read data comes back to the scanner. The other bank is the back buffer and belongs to the drawing engine. The drawing engine hands over writes as a valid/ready stream. Each accepted write passes through one register stage, where address, colour and write enable are held together, and then goes to the back bank.

A swap request is remembered and is carried out only at the next frame-start pulse, so the two banks trade roles only on a frame boundary. Each bank is driven through its own pair of mutually exclusive enables, one for the scan path and one for the drawing path. There is no shared bus. The incoming drawing word is 16 bits wide. Only its 12 colour bits reach memory.

Back-pressure rules: `wr_ready` depends only on `frame_start`, `swap_req` and the remembered request. It is low only in the one cycle in which a swap is carried out. A write transfers on any rising edge where `wr_valid` and `wr_ready` are both high. The engine may hold `wr_valid` high through the stalled cycle, and the write is then accepted on the following cycle.

Top module: `fb_bank_switch`

## Requirements
- R1: After reset `live_bank` is 0. In every cycle the bank numbered `live_bank` has its scan enable set and its draw enable clear, and the other bank has the opposite.
- R2: For each bank, `mem_scan_en` and `mem_draw_en` are never high together.
- R3: A `swap_req` pulse is remembered until it is served. `live_bank` toggles in the cycle after a cycle with `frame_start` high and a request pending or presented in that same cycle, and the request is then cleared. `live_bank` never changes at any other time, including on a `frame_start` with no request.
- R4: `wr_ready` is low exactly in the cycles where `frame_start` is high and a swap request is pending or presented. In every other cycle it is high.
- R5: A write accepted on an edge appears at the bank port on the following cycle. In that cycle `mem_we` is high for that one cycle, the address is {y[8:0], x[8:0]} (y in bits 17:9, x in bits 8:0), and the data is `wr_data[11:0]`. The target is the bank that was the back buffer when the write was accepted.
- R6: Bits 15:12 of `wr_data` are never stored. Data read back equals the low 12 bits of the word that was written.
- R7: `mem_we` is never high for the bank that is live in that cycle.
- R8: In each cycle {scan_y, scan_x} drives the live bank's address. `scan_rdata` returns, one cycle later, the data of the bank that was live when the address was presented.
- R9: Writes made to the back buffer are not visible on `scan_rdata` until a swap makes that bank live. Afterwards they read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| swap_req | input | 1 | Pulse requesting a bank swap at the next frame start |
| live_bank | output | 1 | Number of the bank currently being displayed |
| scan_x | input | 9 | Display scan X address |
| scan_y | input | 9 | Display scan Y address |
| scan_rdata | output | 12 | Colour read from the live bank, one cycle after the address |
| wr_valid | input | 1 | Drawing engine write valid |
| wr_ready | output | 1 | Drawing engine write ready |
| wr_x | input | 9 | Write X address |
| wr_y | input | 9 | Write Y address |
| wr_data | input | 16 | Write word; only bits 11:0 are stored |
| mem_addr | output | 36 | Per-bank address, bank b in bits 18b+17:18b |
| mem_wdata | output | 24 | Per-bank write colour, bank b in bits 12b+11:12b |
| mem_we | output | 2 | Per-bank write enable |
| mem_scan_en | output | 2 | Per-bank scan path enable |
| mem_draw_en | output | 2 | Per-bank drawing path enable |
| mem_rdata | input | 24 | Per-bank read data, bank b in bits 12b+11:12b |

## Verification
A wrong swap state (a lost or duplicated request, or a swap at a time other than frame start) shows at once on `live_bank` and on the per-bank enables in the next cycle. It also shows on `wr_ready` in the frame-start cycle itself. A wrong write target or corrupted write register does not show at the ports until the next swap, when the scanner reads that bank and `scan_rdata` differs from the image the bench expects, one cycle after the address is presented. For this reason the stimulus swaps often and reads back a small set of addresses that are written repeatedly.

// File: rtl/fbsw_pkg.sv
package fbsw_pkg;
  localparam int FBSW_XW = 9;
  localparam int FBSW_YW = 9;
  localparam int FBSW_CW = 12;
  localparam int FBSW_IW = 16;
  localparam int FBSW_NBANK = 2;

  typedef enum logic {ROLE_SCAN = 1'b0, ROLE_DRAW = 1'b1} bank_role_e;

  function automatic logic other_bank(input logic b);
    return ~b;
  endfunction
endpackage

// File: rtl/fbsw_role_ctrl.sv
module fbsw_role_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic frame_start,
  output logic live_q,
  output logic swap_now
);
  logic pend_q;
  logic want;

  assign want     = pend_q | swap_req;
  assign swap_now = frame_start & want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (swap_now) begin
        live_q <= fbsw_pkg::other_bank(live_q);
        pend_q <= 1'b0;
      end else if (swap_req) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbsw_draw_stage.sv
module fbsw_draw_stage #(
  parameter int AW = 18,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] in_addr,
  input  logic [CW-1:0] in_color,
  input  logic          in_bank,
  output logic          q_we,
  output logic          q_bank,
  output logic [AW-1:0] q_addr,
  output logic [CW-1:0] q_color
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_we    <= 1'b0;
      q_bank  <= 1'b1;
      q_addr  <= '0;
      q_color <= '0;
    end else begin
      q_we <= take;
      if (take) begin
        q_bank  <= in_bank;
        q_addr  <= in_addr;
        q_color <= in_color;
      end
    end
  end
endmodule

// File: rtl/fbsw_bank_port.sv
module fbsw_bank_port #(
  parameter int   AW      = 18,
  parameter int   CW      = 12,
  parameter logic BANK_ID = 1'b0
) (
  input  logic          live,
  input  logic [AW-1:0] scan_addr,
  input  logic          d_we,
  input  logic          d_bank,
  input  logic [AW-1:0] d_addr,
  input  logic [CW-1:0] d_color,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] wdata,
  output logic          we,
  output logic          scan_en,
  output logic          draw_en
);
  fbsw_pkg::bank_role_e role;

  assign role    = (live == BANK_ID) ? fbsw_pkg::ROLE_SCAN : fbsw_pkg::ROLE_DRAW;
  assign scan_en = (role == fbsw_pkg::ROLE_SCAN);
  assign draw_en = (role == fbsw_pkg::ROLE_DRAW);

  always_comb begin
    addr  = '0;
    wdata = '0;
    we    = 1'b0;
    unique case (role)
      fbsw_pkg::ROLE_SCAN: addr = scan_addr;
      fbsw_pkg::ROLE_DRAW: begin
        addr  = d_addr;
        wdata = d_color;
        we    = d_we & (d_bank == BANK_ID);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fbsw_read_return.sv
module fbsw_read_return #(
  parameter int CW    = 12,
  parameter int NBANK = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                live,
  input  logic [NBANK*CW-1:0] rdata_all,
  output logic [CW-1:0]       rdata
);
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= live;
  end

  assign rdata = rdata_all[sel_q*CW +: CW];
endmodule

// File: rtl/fb_bank_switch.sv
module fb_bank_switch #(
  parameter int XW = fbsw_pkg::FBSW_XW,
  parameter int YW = fbsw_pkg::FBSW_YW,
  parameter int CW = fbsw_pkg::FBSW_CW,
  parameter int IW = fbsw_pkg::FBSW_IW,
  localparam int AW = XW + YW,
  localparam int NB = fbsw_pkg::FBSW_NBANK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             swap_req,
  output logic             live_bank,
  input  logic [XW-1:0]    scan_x,
  input  logic [YW-1:0]    scan_y,
  output logic [CW-1:0]    scan_rdata,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [XW-1:0]    wr_x,
  input  logic [YW-1:0]    wr_y,
  input  logic [IW-1:0]    wr_data,
  output logic [NB*AW-1:0] mem_addr,
  output logic [NB*CW-1:0] mem_wdata,
  output logic [NB-1:0]    mem_we,
  output logic [NB-1:0]    mem_scan_en,
  output logic [NB-1:0]    mem_draw_en,
  input  logic [NB*CW-1:0] mem_rdata
);
  logic          swap_now;
  logic          take;
  logic          d_we, d_bank;
  logic [AW-1:0] d_addr;
  logic [CW-1:0] d_color;
  logic [AW-1:0] scan_addr;

  fbsw_role_ctrl u_role (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req),
    .frame_start(frame_start), .live_q(live_bank), .swap_now(swap_now)
  );

  assign wr_ready  = ~swap_now;
  assign take      = wr_valid & wr_ready;
  assign scan_addr = {scan_y, scan_x};

  fbsw_draw_stage #(.AW(AW), .CW(CW)) u_draw (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_addr({wr_y, wr_x}), .in_color(wr_data[CW-1:0]),
    .in_bank(fbsw_pkg::other_bank(live_bank)),
    .q_we(d_we), .q_bank(d_bank), .q_addr(d_addr), .q_color(d_color)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    fbsw_bank_port #(.AW(AW), .CW(CW), .BANK_ID(b[0])) u_port (
      .live(live_bank), .scan_addr(scan_addr),
      .d_we(d_we), .d_bank(d_bank), .d_addr(d_addr), .d_color(d_color),
      .addr(mem_addr[b*AW +: AW]), .wdata(mem_wdata[b*CW +: CW]),
      .we(mem_we[b]), .scan_en(mem_scan_en[b]), .draw_en(mem_draw_en[b])
    );
  end

  fbsw_read_return #(.CW(CW), .NBANK(NB)) u_ret (
    .clk(clk), .rst_n(rst_n), .live(live_bank),
    .rdata_all(mem_rdata), .rdata(scan_rdata)
  );
endmodule

// File: rtl/fbsw_checker.sv
module fbsw_checker #(
  parameter int XW = 9,
  parameter int YW = 9,
  parameter int CW = 12,
  parameter int IW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               live_bank,
  input logic [XW-1:0]      scan_x,
  input logic [YW-1:0]      scan_y,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [IW-1:0]      wr_data,
  input logic [2*(XW+YW)-1:0] mem_addr,
  input logic [2*CW-1:0]    mem_wdata,
  input logic [1:0]         mem_we,
  input logic [1:0]         mem_scan_en,
  input logic [1:0]         mem_draw_en
);
  localparam int AW = XW + YW;

  AST_SCAN_ON_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_scan_en[live_bank] && $onehot(mem_scan_en)); // R1
  AST_EN_EXCL_B0: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_scan_en[0] && mem_draw_en[0])); // R2
  AST_EN_EXCL_B1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_scan_en[1] && mem_draw_en[1])); // R2
  AST_SWAP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (live_bank != $past(live_bank)) |-> $past(frame_start)); // R3
  AST_STALL_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> frame_start); // R4
  AST_WE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> $past(wr_valid && wr_ready)); // R5
  AST_WE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we)); // R5
  AST_LOW_BITS_B0: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[0] |-> (mem_wdata[CW-1:0] == $past(wr_data[CW-1:0]))); // R6
  AST_LOW_BITS_B1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[1] |-> (mem_wdata[2*CW-1:CW] == $past(wr_data[CW-1:0]))); // R6
  AST_NO_WE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> !mem_we[live_bank]); // R7
  AST_SCAN_ADDR_B0: assert property (@(posedge clk) disable iff (!rst_n)
    (live_bank == 1'b0) |-> (mem_addr[AW-1:0] == {scan_y, scan_x})); // R8
  AST_SCAN_ADDR_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (live_bank == 1'b1) |-> (mem_addr[2*AW-1:AW] == {scan_y, scan_x})); // R8
endmodule

bind fb_bank_switch fbsw_checker #(.XW(XW), .YW(YW), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .live_bank(live_bank),
  .scan_x(scan_x), .scan_y(scan_y), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .mem_scan_en(mem_scan_en), .mem_draw_en(mem_draw_en)
);

// File: tb/fb_bank_switch_test.sv
`timescale 1ns/1ps
module fb_bank_switch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, swap_req = 1'b0, wr_valid = 1'b0;
  logic [8:0]  scan_x = '0, scan_y = '0, wr_x = '0, wr_y = '0;
  logic [15:0] wr_data = '0;
  logic        live_bank, wr_ready;
  logic [11:0] scan_rdata;
  logic [35:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [1:0]  mem_we, mem_scan_en, mem_draw_en;
  logic [11:0] rd0 = '0, rd1 = '0;
  logic [23:0] mem_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  logic [11:0] dm0 [int];
  logic [11:0] dm1 [int];
  logic [11:0] em0 [int];
  logic [11:0] em1 [int];

  int  m_live = 0, m_pend = 0, m_rdv = 0;
  logic [11:0] m_rd = '0;

  always #2.5 clk = ~clk;

  assign mem_rdata = {rd1, rd0};

  fb_bank_switch uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .swap_req(swap_req),
    .live_bank(live_bank), .scan_x(scan_x), .scan_y(scan_y), .scan_rdata(scan_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_x(wr_x), .wr_y(wr_y),
    .wr_data(wr_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_scan_en(mem_scan_en), .mem_draw_en(mem_draw_en), .mem_rdata(mem_rdata)
  );

  // bank devices: synchronous write, one-cycle read
  always @(posedge clk) begin
    int a0, a1;
    a0 = int'(mem_addr[17:0]);
    a1 = int'(mem_addr[35:18]);
    if (mem_we[0]) dm0[a0] = mem_wdata[11:0];
    if (mem_we[1]) dm1[a1] = mem_wdata[23:12];
    rd0 <= dm0.exists(a0) ? dm0[a0] : 12'h000;
    rd1 <= dm1.exists(a1) ? dm1[a1] : 12'h000;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] em_rd(input int bank, input int key);
    if (bank == 0) return em0.exists(key) ? em0[key] : 12'h000;
    return em1.exists(key) ? em1[key] : 12'h000;
  endfunction

  // one cycle: drive at negedge, check outputs, advance the reference model
  task automatic cyc(input bit v, input int x, input int y, input logic [15:0] d,
                     input bit sr, input bit fs, input int sx, input int sy);
    bit swp, acc;
    int wkey, skey;
    @(negedge clk);
    wr_valid = v; wr_x = x[8:0]; wr_y = y[8:0]; wr_data = d;
    swap_req = sr; frame_start = fs; scan_x = sx[8:0]; scan_y = sy[8:0];
    #1;
    swp = fs && (m_pend != 0 || sr);
    acc = v && !swp;
    chk(live_bank == m_live[0], "R3 live_bank", live_bank, m_live);
    chk(mem_scan_en == (2'b01 << m_live) && mem_draw_en == ~(2'b01 << m_live),
        "R1 enables", {mem_scan_en, mem_draw_en}, m_live);
    chk((mem_scan_en & mem_draw_en) == 2'b00, "R2 exclusive", {mem_scan_en, mem_draw_en}, 0);
    chk(wr_ready == !swp, "R4 wr_ready", wr_ready, !swp);
    chk(mem_we[m_live] == 1'b0, "R7 no write to live", mem_we, 0);
    chk(mem_addr[m_live*18 +: 18] == {scan_y, scan_x}, "R8 scan address",
        mem_addr[m_live*18 +: 18], {scan_y, scan_x});
    if (m_rdv != 0)
      chk(scan_rdata == m_rd, "R9 R6 R8 read data", scan_rdata, m_rd);
    wkey = (y << 9) | x;
    skey = (sy << 9) | sx;
    if (acc) begin
      if (m_live == 0) em1[wkey] = d[11:0];
      else             em0[wkey] = d[11:0];
    end
    m_rd  = em_rd(m_live, skey);
    m_rdv = 1;
    if (swp) begin
      m_live = 1 - m_live;
      m_pend = 0;
    end else if (sr) begin
      m_pend = 1;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1;
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(live_bank == 1'b0, "R1 reset live", live_bank, 0);
    chk(mem_we == 2'b00, "R1 reset we", mem_we, 0);
    chk(mem_scan_en == 2'b01, "R1 reset enables", mem_scan_en, 1);
    rst_n = 1'b1;

    // R5 R6: write bank 1 with upper bits set, scan reads bank 0 (R9)
    for (int i = 0; i < 6; i++) cyc(1, i, 2, 16'hF000 | 16'(i * 16'h111), 0, 0, i, 2);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, i, 2);
    // R3: frame start with no request does nothing
    cyc(1, 511, 511, 16'hEABC, 0, 1, 0, 0);
    // R3: request remembered over several cycles, swap on frame start, R4 stall
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 7, 7, 16'h5123, 0, 1, 0, 0);
    cyc(1, 7, 7, 16'h5123, 0, 0, 0, 0);
    // R9: bank 1 now live, read back what was written
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, i, 2);
    cyc(0, 0, 0, 0, 0, 0, 511, 511);
    // R3: request and frame start in the same cycle, write pending meanwhile
    cyc(1, 3, 1, 16'h0777, 1, 1, 0, 0);
    cyc(1, 3, 1, 16'h0777, 0, 0, 3, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 7, 7);
    // random traffic over a small address set
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 100);
      cyc(($urandom % 3) != 0, int'($urandom % 8), int'($urandom % 4),
          16'($urandom), r < 6, r >= 85, int'($urandom % 8), int'($urandom % 4));
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule